// File: doc/BRIEF.md
# Boundary Scan Register Chain

This block is the data-register side of a boundary-scan port for a small set of device pins. A TAP controller outside the block supplies three state strobes (capture, shift, update) and three instruction-decoded mode lines (external test, clamp, high impedance). Between TDI and TDO the block forms one serial chain of cells. Input pins use observe-only cells. Output pins use capture/update cells whose pad drivers are gated by one control cell per group. Bidirectional pins use cells that observe whichever value is really on the pin.

With no test mode selected, every pad follows its core signal. In external test or clamp, pads are driven from the update flops instead. An internal module-reset input is then held at 0 towards the core. In high-impedance mode every driver is switched off, including the reset pins, which sit outside the chain. Every cell has a safe value. A test reset loads it into both the shift flop and the update flop.

Top module: `bsr_chain`

## Requirements
- R1: The chain has N_IN+N_OUT+N_BID+3 cells. Cell 0 drives TDO and TDI enters the highest cell. While `shift_dr` is high, each rising TCK edge moves every cell one place towards TDO. From cell 0 upwards the order is: input cells, the output control cell, the output data cells, the bidirectional control cell, the bidirectional data cells, and the linkage cell.
- R2: A rising TCK edge with `capture_dr` high loads the following values:
  - input and linkage cells take their pad;
  - output data cells take `core_out_d`;
  - each control cell takes the inverse of its disable value when the core enables that group, and the disable value otherwise;
  - bidirectional cells take the driven value while their driver is on, and `pad_bid_i` while it is off.
- R3: Update flops load from the shift flops only on a falling TCK edge with `update_dr` high. At any other time the driven test values stay unchanged.
- R4: In external test or clamp (high impedance off), pad data comes from the update flops. A group's output enable is 1 exactly when its control cell's update flop differs from that group's disable value. The disable value is 1 for outputs and 0 for bidirectionals by default.
- R5: With no mode line high, the pads of the output and bidirectional groups copy core data and core enables.
- R6: High-impedance mode forces every output enable to 0, including the reset pins. It takes priority over the other modes. Pad data then shows the update flops.
- R7: `core_lrst_o` is 0 in external test or clamp. In every other case, high impedance included, it follows `pad_lrst_i`.
- R8: While `trst_n` is low, and for two rising TCK edges after it rises, all shift and update flops hold their safe values. The safe values are:
  - control cells: their disable value;
  - output cells: OUT_SAFE;
  - bidirectional cells: BID_SAFE;
  - input cells: IN_SAFE;
  - linkage cell: 0.
- R9: Reset pins have no cell in the chain. Their data passes straight through, and their enable passes through unless high-impedance mode is on.
- R10: `core_in_o` and `core_bid_i` always follow `pad_in_i` and `pad_bid_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test reset, active low, asynchronous |
| capture_dr | input | 1 | TAP in capture state |
| shift_dr | input | 1 | TAP in shift state |
| update_dr | input | 1 | TAP in update state |
| mode_extest | input | 1 | External test selected |
| mode_clamp | input | 1 | Clamp selected |
| mode_hiz | input | 1 | All drivers off |
| tdi | input | 1 | Serial in |
| tdo | output | 1 | Serial out (cell 0) |
| pad_in_i | input | N_IN | Input pads |
| core_in_o | output | N_IN | Input pads towards core |
| core_out_d | input | N_OUT | Core output data |
| core_out_oe | input | 1 | Core output group enable |
| pad_out_d | output | N_OUT | Output pad data |
| pad_out_oe | output | 1 | Output group driver enable |
| core_bid_d | input | N_BID | Core bidirectional data |
| core_bid_oe | input | 1 | Core bidirectional group enable |
| pad_bid_i | input | N_BID | Bidirectional pad receive |
| pad_bid_d | output | N_BID | Bidirectional pad drive data |
| pad_bid_oe | output | 1 | Bidirectional group driver enable |
| core_bid_i | output | N_BID | Bidirectional receive towards core |
| pad_lrst_i | input | 1 | Internal module reset pad |
| core_lrst_o | output | 1 | Module reset towards core |
| core_rst_d | input | N_RST | Core data for reset pins |
| core_rst_oe | input | N_RST | Core enables for reset pins |
| pad_rst_d | output | N_RST | Reset pin data |
| pad_rst_oe | output | N_RST | Reset pin enables |

## Verification
The assertions take for granted that the strobes and mode lines change only between clock edges and stay put through a whole TCK period. The hold property reads `update_dr` at a rising edge as the value that was present at the falling edge just before it. The stimulus changes every input a quarter period after the rising edge. At most one TAP strobe is high in any cycle. Mode lines are switched only while no update is in progress, and mixed mode combinations are still applied so that the high-impedance priority is exercised.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  typedef enum logic [1:0] {
    PM_FUNC = 2'd0,
    PM_TEST = 2'd1,
    PM_HIZ  = 2'd2
  } pad_mode_e;

  // High impedance wins over external test and clamp.
  function automatic pad_mode_e decode_mode(input logic ext, input logic clamp, input logic hiz);
    if (hiz)                return PM_HIZ;
    else if (ext || clamp)  return PM_TEST;
    else                    return PM_FUNC;
  endfunction

endpackage

// File: rtl/bsr_rst_sync.sv
module bsr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_nxt;
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/bsr_obs_cell.sv
module bsr_obs_cell #(
  parameter logic SAFE = 1'b0
) (
  input  logic tck,
  input  logic rst_n,
  input  logic cap_en,
  input  logic shf_en,
  input  logic cap_d,
  input  logic si,
  output logic so
);
  logic sh_q;
  logic sh_nxt;

  always_comb begin
    sh_nxt = sh_q;
    if (cap_en)      sh_nxt = cap_d;
    else if (shf_en) sh_nxt = si;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) sh_q <= SAFE;
    else        sh_q <= sh_nxt;
  end

  assign so = sh_q;
endmodule

// File: rtl/bsr_cu_cell.sv
module bsr_cu_cell #(
  parameter logic SAFE = 1'b0
) (
  input  logic tck,
  input  logic rst_n,
  input  logic cap_en,
  input  logic shf_en,
  input  logic upd_en,
  input  logic cap_d,
  input  logic si,
  output logic so,
  output logic upd_q
);
  logic sh_q;
  logic sh_nxt;
  logic up_q;
  logic up_nxt;

  always_comb begin
    sh_nxt = sh_q;
    if (cap_en)      sh_nxt = cap_d;
    else if (shf_en) sh_nxt = si;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) sh_q <= SAFE;
    else        sh_q <= sh_nxt;
  end

  always_comb begin
    up_nxt = up_q;
    if (upd_en) up_nxt = sh_q;
  end

  // Update stage changes on the falling edge.
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) up_q <= SAFE;
    else        up_q <= up_nxt;
  end

  assign so    = sh_q;
  assign upd_q = up_q;
endmodule

// File: rtl/bsr_pad_mux.sv
module bsr_pad_mux
  import bsr_pkg::*;
#(
  parameter int   W   = 4,
  parameter logic DIS = 1'b1
) (
  input  pad_mode_e      mode,
  input  logic [W-1:0]   core_d,
  input  logic           core_oe,
  input  logic [W-1:0]   upd_d,
  input  logic           upd_ctl,
  output logic [W-1:0]   pad_d,
  output logic           pad_oe
);
  always_comb begin
    pad_d = (mode == PM_FUNC) ? core_d : upd_d;
    case (mode)
      PM_FUNC: pad_oe = core_oe;
      PM_TEST: pad_oe = (upd_ctl != DIS);
      default: pad_oe = 1'b0;
    endcase
  end
endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
  import bsr_pkg::*;
#(
  parameter int               N_IN     = 3,
  parameter int               N_OUT    = 4,
  parameter int               N_BID    = 2,
  parameter int               N_RST    = 2,
  parameter logic             OUT_DIS  = 1'b1,
  parameter logic             BID_DIS  = 1'b0,
  parameter logic             IN_SAFE  = 1'b0,
  parameter logic [N_OUT-1:0] OUT_SAFE = 4'b0101,
  parameter logic [N_BID-1:0] BID_SAFE = 2'b10
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             capture_dr,
  input  logic             shift_dr,
  input  logic             update_dr,
  input  logic             mode_extest,
  input  logic             mode_clamp,
  input  logic             mode_hiz,
  input  logic             tdi,
  output logic             tdo,
  input  logic [N_IN-1:0]  pad_in_i,
  output logic [N_IN-1:0]  core_in_o,
  input  logic [N_OUT-1:0] core_out_d,
  input  logic             core_out_oe,
  output logic [N_OUT-1:0] pad_out_d,
  output logic             pad_out_oe,
  input  logic [N_BID-1:0] core_bid_d,
  input  logic             core_bid_oe,
  input  logic [N_BID-1:0] pad_bid_i,
  output logic [N_BID-1:0] pad_bid_d,
  output logic             pad_bid_oe,
  output logic [N_BID-1:0] core_bid_i,
  input  logic             pad_lrst_i,
  output logic             core_lrst_o,
  input  logic [N_RST-1:0] core_rst_d,
  input  logic [N_RST-1:0] core_rst_oe,
  output logic [N_RST-1:0] pad_rst_d,
  output logic [N_RST-1:0] pad_rst_oe
);
  localparam int CHAIN_LEN = N_IN + N_OUT + N_BID + 3;
  localparam int I_OCTL    = N_IN;
  localparam int I_OUT0    = N_IN + 1;
  localparam int I_BCTL    = I_OUT0 + N_OUT;
  localparam int I_BID0    = I_BCTL + 1;
  localparam int I_LINK    = CHAIN_LEN - 1;

  logic                 rst_n_s;
  pad_mode_e            mode;
  logic [CHAIN_LEN-1:0] sr;
  logic [CHAIN_LEN-1:0] si;
  logic [CHAIN_LEN-1:0] cap;
  logic [N_OUT-1:0]     out_upd;
  logic [N_BID-1:0]     bid_upd;
  logic                 octl_upd;
  logic                 bctl_upd;

  bsr_rst_sync #(.STAGES(2)) u_rst (
    .clk(tck), .arst_n(trst_n), .rst_n(rst_n_s)
  );

  assign mode = decode_mode(mode_extest, mode_clamp, mode_hiz);
  assign si   = {tdi, sr[CHAIN_LEN-1:1]};
  assign tdo  = sr[0];

  always_comb begin
    cap                      = '0;
    cap[N_IN-1:0]            = pad_in_i;
    cap[I_OCTL]              = core_out_oe ? ~OUT_DIS : OUT_DIS;
    cap[I_OUT0 +: N_OUT]     = core_out_d;
    cap[I_BCTL]              = core_bid_oe ? ~BID_DIS : BID_DIS;
    cap[I_BID0 +: N_BID]     = pad_bid_oe ? pad_bid_d : pad_bid_i;
    cap[I_LINK]              = pad_lrst_i;
  end

  for (genvar g = 0; g < N_IN; g++) begin : g_in
    bsr_obs_cell #(.SAFE(IN_SAFE)) u_cell (
      .tck(tck), .rst_n(rst_n_s), .cap_en(capture_dr), .shf_en(shift_dr),
      .cap_d(cap[g]), .si(si[g]), .so(sr[g])
    );
  end

  bsr_cu_cell #(.SAFE(OUT_DIS)) u_octl (
    .tck(tck), .rst_n(rst_n_s), .cap_en(capture_dr), .shf_en(shift_dr),
    .upd_en(update_dr), .cap_d(cap[I_OCTL]), .si(si[I_OCTL]),
    .so(sr[I_OCTL]), .upd_q(octl_upd)
  );

  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    bsr_cu_cell #(.SAFE(OUT_SAFE[g])) u_cell (
      .tck(tck), .rst_n(rst_n_s), .cap_en(capture_dr), .shf_en(shift_dr),
      .upd_en(update_dr), .cap_d(cap[I_OUT0+g]), .si(si[I_OUT0+g]),
      .so(sr[I_OUT0+g]), .upd_q(out_upd[g])
    );
  end

  bsr_cu_cell #(.SAFE(BID_DIS)) u_bctl (
    .tck(tck), .rst_n(rst_n_s), .cap_en(capture_dr), .shf_en(shift_dr),
    .upd_en(update_dr), .cap_d(cap[I_BCTL]), .si(si[I_BCTL]),
    .so(sr[I_BCTL]), .upd_q(bctl_upd)
  );

  for (genvar g = 0; g < N_BID; g++) begin : g_bid
    bsr_cu_cell #(.SAFE(BID_SAFE[g])) u_cell (
      .tck(tck), .rst_n(rst_n_s), .cap_en(capture_dr), .shf_en(shift_dr),
      .upd_en(update_dr), .cap_d(cap[I_BID0+g]), .si(si[I_BID0+g]),
      .so(sr[I_BID0+g]), .upd_q(bid_upd[g])
    );
  end

  // Linkage cell: observed only, its value never drives the core.
  bsr_obs_cell #(.SAFE(1'b0)) u_link (
    .tck(tck), .rst_n(rst_n_s), .cap_en(capture_dr), .shf_en(shift_dr),
    .cap_d(cap[I_LINK]), .si(si[I_LINK]), .so(sr[I_LINK])
  );

  bsr_pad_mux #(.W(N_OUT), .DIS(OUT_DIS)) u_out_mux (
    .mode(mode), .core_d(core_out_d), .core_oe(core_out_oe),
    .upd_d(out_upd), .upd_ctl(octl_upd), .pad_d(pad_out_d), .pad_oe(pad_out_oe)
  );

  bsr_pad_mux #(.W(N_BID), .DIS(BID_DIS)) u_bid_mux (
    .mode(mode), .core_d(core_bid_d), .core_oe(core_bid_oe),
    .upd_d(bid_upd), .upd_ctl(bctl_upd), .pad_d(pad_bid_d), .pad_oe(pad_bid_oe)
  );

  assign core_in_o   = pad_in_i;
  assign core_bid_i  = pad_bid_i;
  assign core_lrst_o = (mode == PM_TEST) ? 1'b0 : pad_lrst_i;
  assign pad_rst_d   = core_rst_d;
  assign pad_rst_oe  = (mode == PM_HIZ) ? '0 : core_rst_oe;
endmodule

// File: rtl/bsr_chain_chk.sv
module bsr_chain_chk #(
  parameter int N_OUT = 4,
  parameter int N_RST = 2
) (
  input logic             tck,
  input logic             trst_n,
  input logic             mode_extest,
  input logic             mode_clamp,
  input logic             mode_hiz,
  input logic             update_dr,
  input logic [N_OUT-1:0] core_out_d,
  input logic             core_out_oe,
  input logic [N_OUT-1:0] pad_out_d,
  input logic             pad_out_oe,
  input logic             pad_bid_oe,
  input logic [N_RST-1:0] core_rst_oe,
  input logic [N_RST-1:0] pad_rst_oe,
  input logic             core_lrst_o
);
  logic in_test;
  assign in_test = (mode_extest || mode_clamp) && !mode_hiz;

  p_hiz_all_off_r6: assert property (@(posedge tck) disable iff (!trst_n)
    mode_hiz |-> (!pad_out_oe && !pad_bid_oe && (pad_rst_oe == '0)));

  p_link_low_r7: assert property (@(posedge tck) disable iff (!trst_n)
    in_test |-> !core_lrst_o);

  p_func_follow_r5: assert property (@(posedge tck) disable iff (!trst_n)
    (!mode_hiz && !mode_extest && !mode_clamp) |->
      ((pad_out_d == core_out_d) && (pad_out_oe == core_out_oe)));

  p_rst_pins_r9: assert property (@(posedge tck) disable iff (!trst_n)
    !mode_hiz |-> (pad_rst_oe == core_rst_oe));

  p_upd_hold_r3: assert property (@(posedge tck) disable iff (!trst_n)
    (in_test && $past(in_test) && !update_dr) |-> $stable(pad_out_d));
endmodule

bind bsr_chain bsr_chain_chk #(.N_OUT(N_OUT), .N_RST(N_RST)) u_chk (
  .tck(tck), .trst_n(trst_n), .mode_extest(mode_extest), .mode_clamp(mode_clamp),
  .mode_hiz(mode_hiz), .update_dr(update_dr), .core_out_d(core_out_d),
  .core_out_oe(core_out_oe), .pad_out_d(pad_out_d), .pad_out_oe(pad_out_oe),
  .pad_bid_oe(pad_bid_oe), .core_rst_oe(core_rst_oe), .pad_rst_oe(pad_rst_oe),
  .core_lrst_o(core_lrst_o)
);

// File: tb/sim_bsr_chain.sv
module sim_bsr_chain;
  localparam int TCK_PERIOD = 10;
  localparam int NI = 3, NO = 4, NB = 2, NR = 2;
  localparam int LEN = NI + NO + NB + 3;
  localparam bit ODIS = 1'b1, BDIS = 1'b0;
  localparam bit [NO-1:0] OSAFE = 4'b0101;
  localparam bit [NB-1:0] BSAFE = 2'b10;

  logic tck, trst_n, capture_dr, shift_dr, update_dr;
  logic mode_extest, mode_clamp, mode_hiz, tdi, tdo;
  logic [NI-1:0] pad_in_i, core_in_o;
  logic [NO-1:0] core_out_d, pad_out_d;
  logic core_out_oe, pad_out_oe;
  logic [NB-1:0] core_bid_d, pad_bid_i, pad_bid_d, core_bid_i;
  logic core_bid_oe, pad_bid_oe;
  logic pad_lrst_i, core_lrst_o;
  logic [NR-1:0] core_rst_d, core_rst_oe, pad_rst_d, pad_rst_oe;

  bsr_chain u0 (.*);

  int n_cmp = 0, n_bad = 0;
  string tdo_tag = "R1";
  string pad_tag = "";

  // Reference model state
  bit chain_m[$];
  bit [NO-1:0] oupd_m;
  bit [NB-1:0] bupd_m;
  bit octl_m, bctl_m;
  bit rs1, rs2;

  initial tck = 1'b0;
  always #(TCK_PERIOD/2) tck = ~tck;

  function automatic void model_reset();
    chain_m.delete();
    for (int i = 0; i < NI; i++) chain_m.push_back(1'b0);
    chain_m.push_back(ODIS);
    for (int i = 0; i < NO; i++) chain_m.push_back(OSAFE[i]);
    chain_m.push_back(BDIS);
    for (int i = 0; i < NB; i++) chain_m.push_back(BSAFE[i]);
    chain_m.push_back(1'b0);
    oupd_m = OSAFE; bupd_m = BSAFE; octl_m = ODIS; bctl_m = BDIS;
  endfunction

  function automatic bit m_hiz();  return mode_hiz; endfunction
  function automatic bit m_test(); return (mode_extest || mode_clamp) && !mode_hiz; endfunction
  function automatic bit m_func(); return !mode_extest && !mode_clamp && !mode_hiz; endfunction

  function automatic bit [NO-1:0] e_out_d(); return m_func() ? core_out_d : oupd_m; endfunction
  function automatic bit e_out_oe();
    if (m_hiz()) return 1'b0;
    if (m_test()) return octl_m != ODIS;
    return core_out_oe;
  endfunction
  function automatic bit [NB-1:0] e_bid_d(); return m_func() ? core_bid_d : bupd_m; endfunction
  function automatic bit e_bid_oe();
    if (m_hiz()) return 1'b0;
    if (m_test()) return bctl_m != BDIS;
    return core_bid_oe;
  endfunction

  function automatic void model_capture();
    bit nq[$];
    bit [NB-1:0] bd;
    bd = e_bid_oe() ? e_bid_d() : pad_bid_i;
    for (int i = 0; i < NI; i++) nq.push_back(pad_in_i[i]);
    nq.push_back(core_out_oe ? !ODIS : ODIS);
    for (int i = 0; i < NO; i++) nq.push_back(core_out_d[i]);
    nq.push_back(core_bid_oe ? !BDIS : BDIS);
    for (int i = 0; i < NB; i++) nq.push_back(bd[i]);
    nq.push_back(pad_lrst_i);
    chain_m = nq;
  endfunction

  function automatic void model_update();
    octl_m = chain_m[NI];
    for (int i = 0; i < NO; i++) oupd_m[i] = chain_m[NI+1+i];
    bctl_m = chain_m[NI+1+NO];
    for (int i = 0; i < NB; i++) bupd_m[i] = chain_m[NI+2+NO+i];
  endfunction

  function automatic void chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endfunction

  function automatic void compare_all();
    string pt, tt;
    pt = m_hiz() ? "R6" : (m_test() ? "R4" : "R5");
    if (pad_tag != "") pt = pad_tag;
    tt = tdo_tag;
    if (!rs2) begin pt = "R8"; tt = "R8"; end
    chk(tt, "tdo", tdo, chain_m[0]);
    if (!m_hiz()) chk(pt, "pad_out_d", pad_out_d, e_out_d());
    chk(pt, "pad_out_oe", pad_out_oe, e_out_oe());
    if (!m_hiz()) chk(pt, "pad_bid_d", pad_bid_d, e_bid_d());
    chk(pt, "pad_bid_oe", pad_bid_oe, e_bid_oe());
    chk("R7", "core_lrst_o", core_lrst_o, m_test() ? 1'b0 : pad_lrst_i);
    chk("R9", "pad_rst_d", pad_rst_d, core_rst_d);
    chk(m_hiz() ? "R6" : "R9", "pad_rst_oe", pad_rst_oe, m_hiz() ? '0 : core_rst_oe);
    chk("R10", "core_in_o", core_in_o, pad_in_i);
    chk("R10", "core_bid_i", core_bid_i, pad_bid_i);
  endfunction

  // Model runs in step with the clock; compares at three quarters of the period.
  initial begin
    model_reset();
    rs1 = 0; rs2 = 0;
    forever begin
      @(posedge tck);
      if (!trst_n) begin rs1 = 0; rs2 = 0; model_reset(); end
      else begin
        if (!rs2) model_reset();
        else if (capture_dr) model_capture();
        else if (shift_dr) begin void'(chain_m.pop_front()); chain_m.push_back(tdi); end
        rs2 = rs1; rs1 = 1'b1;
      end
      @(negedge tck);
      if (!trst_n) begin rs1 = 0; rs2 = 0; model_reset(); end
      else if (rs2 && update_dr) model_update();
      #(TCK_PERIOD/4);
      if (!trst_n) begin rs1 = 0; rs2 = 0; model_reset(); end
      compare_all();
    end
  end

  task automatic tick(); @(posedge tck); #(TCK_PERIOD/4); endtask

  task automatic ops(bit c, bit s, bit u); capture_dr = c; shift_dr = s; update_dr = u; endtask

  task automatic rand_data();
    pad_in_i = $urandom; core_out_d = $urandom; core_out_oe = $urandom;
    core_bid_d = $urandom; core_bid_oe = $urandom; pad_bid_i = $urandom;
    pad_lrst_i = $urandom; core_rst_d = $urandom; core_rst_oe = $urandom;
  endtask

  task automatic shift_n(int n, string tag);
    tdo_tag = tag;
    ops(0, 1, 0);
    for (int i = 0; i < n; i++) begin tdi = $urandom; tick(); end
    ops(0, 0, 0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(TCK_PERIOD * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    trst_n = 0; ops(0, 0, 0); tdi = 0;
    mode_extest = 0; mode_clamp = 0; mode_hiz = 0;
    pad_in_i = 0; core_out_d = 0; core_out_oe = 0; core_bid_d = 0; core_bid_oe = 0;
    pad_bid_i = 0; pad_lrst_i = 1; core_rst_d = 0; core_rst_oe = 0;
    repeat (3) tick();
    // R8: reset state, safe values visible on pads and at TDO
    trst_n = 1; tdo_tag = "R8"; pad_tag = "R8";
    repeat (3) tick();
    mode_extest = 1; tick();
    shift_n(LEN, "R8");
    mode_extest = 0; pad_tag = ""; tdo_tag = "R1";
    // R5, R9, R10: functional pass-through
    for (int i = 0; i < 20; i++) begin rand_data(); tick(); end
    // R2: capture then read out
    rand_data(); ops(1, 0, 0); tick();
    shift_n(LEN, "R2");
    // R1: shift a pattern; R3/R4: update it and drive
    shift_n(LEN, "R1");
    mode_extest = 1; pad_tag = "R3"; ops(0, 0, 1); tick(); ops(0, 0, 0);
    for (int i = 0; i < 4; i++) begin rand_data(); tick(); end
    shift_n(LEN, "R1");
    ops(0, 0, 1); tick(); ops(0, 0, 0); pad_tag = "";
    // R2: bidirectional capture with drivers on in test mode
    tdi = 0; ops(0, 1, 0);
    for (int i = 0; i < LEN; i++) begin tdi = (i == LEN-1-NB-1) ? 1'b1 : 1'b0; tick(); end
    ops(0, 0, 1); tick();
    rand_data(); ops(1, 0, 0); tick();
    shift_n(LEN, "R2");
    // R4, R7: clamp
    mode_extest = 0; mode_clamp = 1;
    for (int i = 0; i < 6; i++) begin rand_data(); tick(); end
    // R6: high impedance on top of external test
    mode_clamp = 0; mode_extest = 1; mode_hiz = 1;
    for (int i = 0; i < 6; i++) begin rand_data(); tick(); end
    mode_hiz = 0; mode_extest = 0;
    // Random traffic with a mid-run test reset (R8)
    tdo_tag = "R1";
    for (int i = 0; i < 600; i++) begin
      int op;
      if (i == 300) trst_n = 0;
      if (i == 302) trst_n = 1;
      op = $urandom_range(0, 3);
      ops(op == 1, op == 2, op == 3);
      tdi = $urandom;
      if (op != 3 && $urandom_range(0, 15) == 0) begin
        mode_extest = $urandom; mode_clamp = $urandom; mode_hiz = ($urandom_range(0, 3) == 0);
      end
      rand_data();
      tick();
    end
    ops(0, 0, 0);
    tick();
    finish_run();
  end
endmodule